// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small processor: an eight-entry register file, a shared function unit holding an arithmetic/logic unit and a shifter, and two steering multiplexers. Every cycle a single 16-bit control word chooses the operands, the operation, the source of the write-back value and whether a register is loaded at all. A sequencer that sits outside the block presents one control word per clock cycle.

Two combinational read ports feed an A bus and a register-side B operand. The B bus carries either that register or an external constant. The write-back value is either the function-unit result or an external data word. The A bus is exported as an address output and the B bus as a data output, so a surrounding memory can be addressed and fed by the same control word. Four status flags (zero, negative, carry, overflow) describe the current function-unit result combinationally. The register width is a parameter (`WIDTH`, default 8).

Top module: `cw_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to zero on the next rising clock edge.
- R2: The control word is decoded MSB first as: destination index [15:13], A-read index [12:10], B-read index [9:7], B-source bit [6], function code [5:2], write-back source bit [1], write enable [0].
- R3: With bit [6] = 0 the B bus carries the register named by [9:7]; with bit [6] = 1 it carries `const_in`.
- R4: With bit [1] = 0 the function-unit result is written back; with bit [1] = 1 `data_in` is written back.
- R5: With bit [0] = 1 the register named by [15:13] is loaded on the rising edge; with bit [0] = 0 no register changes.
- R6: Function codes with bit 3 clear compute A + Y + code[0] where Y is 0, B, NOT B or all ones for code[2:1] = 00, 01, 10, 11 (so 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A-B, 0110 A-1, 0111 A).
- R7: Codes 1000, 1001, 1010, 1011 give A AND B, A OR B, A XOR B and NOT A.
- R8: Codes 1100, 1101, 1110, 1111 give B, B shifted right by one with zero fill, B shifted left by one with zero fill, and zero; code 1110 with operand 0x33 from R6 into R4 leaves 0x66 in R4.
- R9: `flag_z` is high when the result is zero and `flag_n` equals its MSB; for codes 0xxx `flag_c` is the carry out of the addition and `flag_v` its two's-complement overflow, while for codes 1xxx both are zero.
- R10: `addr_out` always shows the register named by [12:10] and `data_out` the B bus, whether or not a write takes place.
- R11: All eight registers, R0 and R7 included, are ordinary storage; R5 = R0 + R3 yields 0x08 from 0x05 and 0x03, and 0x23 from 0x07 and 0x1C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Control word for this cycle |
| const_in | input | WIDTH | External constant for the B bus |
| data_in | input | WIDTH | External write-back data |
| addr_out | output | WIDTH | A bus |
| data_out | output | WIDTH | B bus |
| flag_v | output | 1 | Two's-complement overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result MSB |
| flag_z | output | 1 | Result is zero |

## Verification
The hard part is reaching a specific operand pair in two registers before an operation, since every register value must itself be written through the control word. The bench seeds R1 and R2 through the external-data write-back path, then issues each of the sixteen function codes over a grid of boundary operands (0x00, 0x01, 0x7F, 0x80, 0xFF, 0x5A), checking flags and buses live and reading the destination back through the A bus. Suppressed writes are shown by attempting to overwrite a known value and reading it back.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int CW_W   = 16;
  localparam int IDX_W  = 3;
  localparam int NREG   = 1 << IDX_W;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic [IDX_W-1:0]  dst;
    logic [IDX_W-1:0]  rda;
    logic [IDX_W-1:0]  rdb;
    logic              b_const;
    logic [CODE_W-1:0] code;
    logic              wb_ext;
    logic              wen;
  } ctrl_t;

  typedef enum logic [1:0] {
    SH_PASS = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT = 2'b10,
    SH_ZERO = 2'b11
  } shift_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logic_e;
endpackage

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][WIDTH-1:0] regs;

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (we && (waddr == IDX_W'(i))) begin
        regs[i] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (regs == '0))
    else $error("register bank not cleared by reset");

  p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(waddr)] == $past(wdata)))
    else $error("enabled write did not land");

  p_no_write_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs))
    else $error("register changed without write enable");
endmodule

// File: rtl/alu_unit.sv
module alu_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       code,
  output logic [WIDTH-1:0] g,
  output logic             carry,
  output logic             ovf
);
  import dp_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y_op;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] lres;
  logic             is_logic;

  assign is_logic = code[3];

  always_comb begin
    unique case (code[2:1])
      2'b00:   y_op = '0;
      2'b01:   y_op = b;
      2'b10:   y_op = ~b;
      default: y_op = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y_op} + {{WIDTH{1'b0}}, code[0]};

  always_comb begin
    unique case (logic_e'(code[1:0]))
      LG_AND:  lres = a & b;
      LG_OR:   lres = a | b;
      LG_XOR:  lres = a ^ b;
      default: lres = ~a;
    endcase
  end

  always_comb begin
    if (is_logic) begin
      g     = lres;
      carry = 1'b0;
      ovf   = 1'b0;
    end else begin
      g     = sum[WIDTH-1:0];
      carry = sum[WIDTH];
      ovf   = (a[MSB] == y_op[MSB]) && (sum[MSB] != a[MSB]);
    end
  end

  always_comb begin
    if (code == 4'b0000) p_pass_nocarry_r6: assert (!carry && g == a)
      else $error("transfer code produced carry or changed A");
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] h
);
  import dp_pkg::*;

  always_comb begin
    unique case (shift_e'(sel))
      SH_PASS:  h = b;
      SH_RIGHT: h = {1'b0, b[WIDTH-1:1]};
      SH_LEFT:  h = {b[WIDTH-2:0], 1'b0};
      default:  h = '0;
    endcase
  end

  always_comb begin
    if (sel == 2'b10) p_left_fill_r8: assert (h[0] == 1'b0)
      else $error("left shift did not fill with zero");
    if (sel == 2'b01) p_right_fill_r8: assert (h[WIDTH-1] == 1'b0)
      else $error("right shift did not fill with zero");
  end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      ctrl_word,
  input  logic [WIDTH-1:0] const_in,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] addr_out,
  output logic [WIDTH-1:0] data_out,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_z
);
  import dp_pkg::*;

  ctrl_t            cw;
  logic [WIDTH-1:0] bus_a;
  logic [WIDTH-1:0] reg_b;
  logic [WIDTH-1:0] bus_b;
  logic [WIDTH-1:0] alu_g;
  logic [WIDTH-1:0] shf_h;
  logic [WIDTH-1:0] fu_res;
  logic [WIDTH-1:0] wb_val;
  logic             alu_c;
  logic             alu_v;
  logic             sel_shift;

  assign cw = ctrl_t'(ctrl_word);

  reg_bank #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cw.wen),
    .waddr   (cw.dst),
    .wdata   (wb_val),
    .raddr_a (cw.rda),
    .raddr_b (cw.rdb),
    .rdata_a (bus_a),
    .rdata_b (reg_b)
  );

  assign bus_b = cw.b_const ? const_in : reg_b;

  alu_unit #(.WIDTH(WIDTH)) u_alu (
    .a     (bus_a),
    .b     (bus_b),
    .code  (cw.code),
    .g     (alu_g),
    .carry (alu_c),
    .ovf   (alu_v)
  );

  shift_unit #(.WIDTH(WIDTH)) u_shf (
    .b   (bus_b),
    .sel (cw.code[1:0]),
    .h   (shf_h)
  );

  assign sel_shift = cw.code[3] & cw.code[2];
  assign fu_res    = sel_shift ? shf_h : alu_g;
  assign wb_val    = cw.wb_ext ? data_in : fu_res;

  assign addr_out = bus_a;
  assign data_out = bus_b;
  assign flag_z   = (fu_res == '0);
  assign flag_n   = fu_res[WIDTH-1];
  assign flag_c   = sel_shift ? 1'b0 : alu_c;
  assign flag_v   = sel_shift ? 1'b0 : alu_v;

  always_comb begin
    if (cw.b_const) p_bus_b_const_r3: assert (data_out == const_in)
      else $error("B bus does not carry the constant");
    if (sel_shift) p_shift_flags_r9: assert (!flag_c && !flag_v)
      else $error("carry or overflow raised for shifter result");
  end
endmodule

// File: tb/test_cw_datapath.sv
module test_cw_datapath;
  localparam int W = 8;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  ctrl_word = '0;
  logic [W-1:0] const_in = '0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] addr_out, data_out;
  logic         flag_v, flag_c, flag_n, flag_z;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  cw_datapath #(.WIDTH(W)) i_cw_datapath (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] mk(input int da, input int aa, input int ba,
                                     input int mb, input int fs, input int md,
                                     input int rw);
    return {da[2:0], aa[2:0], ba[2:0], mb[0], fs[3:0], md[0], rw[0]};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // expected {v, c, result} from the requirement tables
  function automatic logic [W+1:0] model(input int fs, input int a, input int b);
    int ua, ub, uy, cin, tot, sa, sy, st;
    logic [W-1:0] r;
    logic c, v;
    c = 0; v = 0; r = '0;
    ua = a; ub = b;
    if (fs < 8) begin
      case (fs / 2)
        0: uy = 0;
        1: uy = ub;
        2: uy = (~ub) & 32'hFF;
        default: uy = 32'hFF;
      endcase
      cin = fs % 2;
      tot = ua + uy + cin;
      r = tot[W-1:0];
      c = tot > 255;
      sa = (ua > 127) ? ua - 256 : ua;
      sy = (uy > 127) ? uy - 256 : uy;
      st = sa + sy + cin;
      v = (st > 127) || (st < -128);
    end else begin
      case (fs)
        8:  r = W'(ua & ub);
        9:  r = W'(ua | ub);
        10: r = W'(ua ^ ub);
        11: r = W'(~ua);
        12: r = W'(ub);
        13: r = W'(ub / 2);
        14: r = W'(ub * 2);
        default: r = '0;
      endcase
    end
    return {v, c, r};
  endfunction

  task automatic put(input int idx, input int val);
    @(negedge clk);
    ctrl_word = mk(idx, 0, 0, 0, 0, 1, 1);
    data_in = W'(val);
  endtask

  task automatic peek(input int idx, output int val);
    @(negedge clk);
    ctrl_word = mk(0, idx, 0, 0, 0, 0, 0);
    #1 val = addr_out;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
    logic [W+1:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      peek(i, v);
      chk("R1 reset register", v, 0);
    end

    // R11/R2: each register holds its own value, R0 and R7 included
    for (int i = 0; i < 8; i++) put(i, 8'h10 + i * 8'h11);
    for (int i = 0; i < 8; i++) begin
      peek(i, v);
      chk("R11 register storage", v, 8'h10 + i * 8'h11);
    end

    // R11: R5 = R0 + R3 examples
    put(0, 8'h05); put(3, 8'h03);
    @(negedge clk) ctrl_word = 16'b101_000_011_0_0010_0_1;
    peek(5, v); chk("R11 R5=R0+R3 first", v, 8'h08);
    put(0, 8'h07); put(3, 8'h1C);
    @(negedge clk) ctrl_word = 16'b101_000_011_0_0010_0_1;
    peek(5, v); chk("R11 R5=R0+R3 second", v, 8'h23);

    // R8/R2: shift-left example word
    put(6, 8'h33);
    @(negedge clk) ctrl_word = 16'b1000101100111001;
    peek(4, v); chk("R8 R4=sl R6", v, 8'h66);

    // R5/R10: write suppressed, buses still live
    put(5, 8'hAA); put(2, 8'h3C);
    @(negedge clk);
    ctrl_word = mk(5, 5, 2, 0, 0, 1, 0);
    data_in = 8'h11;
    #1;
    chk("R10 addr_out without write", addr_out, 8'hAA);
    chk("R10 data_out without write", data_out, 8'h3C);
    peek(5, v); chk("R5 no write when disabled", v, 8'hAA);

    // R3/R4: constant on B bus, function result written
    put(1, 8'h40);
    @(negedge clk);
    ctrl_word = mk(7, 1, 2, 1, 2, 0, 1);
    const_in = 8'h25;
    #1 chk("R3 B bus carries constant", data_out, 8'h25);
    peek(7, v); chk("R4 R7=R1+const", v, 8'h65);
    // R3: register on B bus when bit 6 clear
    @(negedge clk);
    ctrl_word = mk(0, 1, 2, 0, 0, 0, 0);
    #1 chk("R3 B bus carries register", data_out, 8'h3C);
    // R4: external data chosen over result
    @(negedge clk);
    ctrl_word = mk(6, 1, 2, 0, 2, 1, 1);
    data_in = 8'h9E;
    peek(6, v); chk("R4 external write-back", v, 8'h9E);

    // R6-R9: sweep of all codes over boundary operands
    for (int fs = 0; fs < 16; fs++) begin
      for (int ia = 0; ia < 6; ia++) begin
        for (int ib = 0; ib < 6; ib++) begin
          put(1, vals[ia]);
          put(2, vals[ib]);
          e = model(fs, vals[ia], vals[ib]);
          @(negedge clk);
          ctrl_word = mk(3, 1, 2, 0, fs, 0, 1);
          #1;
          chk("R10 addr_out during op", addr_out, vals[ia]);
          chk("R9 zero flag", flag_z, (e[W-1:0] == 0));
          chk("R9 negative flag", flag_n, e[W-1]);
          chk("R9 carry flag", flag_c, e[W]);
          chk("R9 overflow flag", flag_v, e[W+1]);
          peek(3, v);
          if (fs < 8) chk("R6 arithmetic result", v, e[W-1:0]);
          else if (fs < 12) chk("R7 logic result", v, e[W-1:0]);
          else chk("R8 shifter result", v, e[W-1:0]);
        end
      end
    end

    // R1: reset after use
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    peek(6, v); chk("R1 reset clears used register", v, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule